// File: doc/BRIEF.md
# Parity-Protected Direct-Mapped Cache

This block is a one-word-per-line, direct-mapped cache lookup. The tag store and the data store are plain synchronous RAMs. Each stored word carries one extra bit that holds its even parity. A lookup reads both arrays. It checks the parity of both words it gets back. It then decides between a hit and a miss. A word with bad parity is never returned. The lookup is turned into a miss, and the line is fetched again from backing memory through a request/acknowledge refill port. Each array drives its own bit on a two-bit error vector for the one cycle in which it returns a bad word.

The parameter `PARITY_EN` chooses at compile time whether the parity bits and the checkers exist. When it is zero, the arrays are one bit narrower and the error vector stays low. For fault-injection tests, a test-only port flips one chosen bit of one stored word and leaves the stored parity bit alone.

Top module: `parity_dm_cache`

## Requirements
- R1: After reset, every entry is invalid, so the first lookup of any address misses. Out of reset `req_ready` is 1, and `mem_req`, `rsp_valid` and `par_err` are 0.
- R2: The cache accepts a request when `req_valid` and `req_ready` are both high, and reads it in the following cycle. If the lookup misses, `rsp_valid` stays low in that cycle. From the next cycle `mem_req` is high with `mem_addr` equal to the request address, and it holds until `mem_ack`. In the cycle of `mem_ack`, `rsp_valid`=1 and `rsp_hit`=0, and `rsp_data` equals `mem_data`.
- R3: A lookup of a valid entry whose tag matches and whose words have good parity answers in the cycle after acceptance. In that cycle `rsp_valid`=1 and `rsp_hit`=1, and `rsp_data` is the stored word. No refill is requested.
- R4: The index is address bits [IDX_W-1:0] and the tag is the remaining upper bits. An address whose index matches but whose tag differs misses, and its refill replaces the entry.
- R5: `req_ready` is low from acceptance until the cycle in which the response is given, and high again in the cycle after it.
- R6: Every write, refills included, stores even parity computed over the word. A freshly refilled entry therefore reads back with `par_err`=0.
- R7: A data word with bad parity sets `par_err[1]` for exactly the lookup cycle. That lookup is not a hit, and a refill follows.
- R8: A tag word with bad parity sets `par_err[0]` for exactly the lookup cycle. It forces a miss and a refill even when the stored tag bits equal the address tag.
- R9: A refill rewrites the tag and the data word with fresh parity. The next lookup of that address hits with no error.
- R10: While `inj_en` is high in idle, `req_ready` is 0. Injection takes priority over a request. Two cycles later the cache is idle again. Bit `inj_bit` of the word at `inj_idx` has then been inverted in the data array (`inj_sel`=1) or the tag array (`inj_sel`=0), and its parity bit has not changed.
- R11: An invalid entry never reports a parity error, even when it was corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Cache idle and able to accept a lookup |
| req_addr | input | ADDR_W | Word address of the lookup |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_data | output | DATA_W | Response word |
| mem_req | output | 1 | Refill request, held until acknowledged |
| mem_addr | output | ADDR_W | Refill address |
| mem_ack | input | 1 | Refill word present on `mem_data` |
| mem_data | input | DATA_W | Refill word |
| par_err | output | 2 | Parity error pulse: bit 0 tag array, bit 1 data array |
| inj_en | input | 1 | Test only: start a bit flip |
| inj_sel | input | 1 | Test only: 1 selects the data array, 0 the tag array |
| inj_idx | input | IDX_W | Test only: entry to corrupt |
| inj_bit | input | BIT_W | Test only: bit to invert |

## Verification
The checker watches several properties on every cycle:
- a refill request holds with a stable address until it is acknowledged;
- a hit never coincides with a parity error;
- every parity error is followed by a refill request;
- error pulses last one cycle;
- the cache refuses requests while busy or while an injection is pending.

Some behaviour depends on stored contents, and only the bench's scenarios can show it:
- which data comes back;
- that an injected bit actually corrupts the chosen array;
- that a refill clears the corruption;
- that corrupted invalid entries stay silent;
- that a tag with bad parity misses even when its bits match.

// File: rtl/parity_dm_cache.sv
module parity_dm_cache #(
  parameter int ADDR_W    = 12,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 32,
  parameter bit PARITY_EN = 1'b1,
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic [1:0]        par_err,
  input  logic              inj_en,
  input  logic              inj_sel,
  input  logic [IDX_W-1:0]  inj_idx,
  input  logic [BIT_W-1:0]  inj_bit
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int PW    = PARITY_EN ? 1 : 0;
  localparam int TW    = TAG_W + PW;
  localparam int DW    = DATA_W + PW;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_INJ} st_t;

  st_t               state;
  logic [TW-1:0]     tag_ram [DEPTH];
  logic [DW-1:0]     dat_ram [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [TW-1:0]     tag_q, tag_fill, tag_wd;
  logic [DW-1:0]     dat_q, dat_fill, dat_wd;
  logic [ADDR_W-1:0] addr_q;
  logic              inj_sel_q;
  logic [IDX_W-1:0]  inj_idx_q;
  logic [BIT_W-1:0]  inj_bit_q;
  logic              tag_bad, dat_bad, hit_c, look_vld;

  wire [IDX_W-1:0] idx_q  = addr_q[IDX_W-1:0];
  wire [TAG_W-1:0] atag_q = addr_q[ADDR_W-1:IDX_W];
  wire             take_inj = (state == S_IDLE) && inj_en;
  wire             take_req = (state == S_IDLE) && !inj_en && req_valid;
  wire             fill_we  = (state == S_FILL) && mem_ack;
  wire             inj_we   = (state == S_INJ);
  wire [IDX_W-1:0] rd_idx   = inj_en ? inj_idx : req_addr[IDX_W-1:0];
  wire [IDX_W-1:0] wr_idx   = inj_we ? inj_idx_q : idx_q;

  generate
    if (PARITY_EN) begin : g_par
      assign tag_fill = {^atag_q, atag_q};
      assign dat_fill = {^mem_data, mem_data};
      assign tag_bad  = ^tag_q;
      assign dat_bad  = ^dat_q;
    end else begin : g_nopar
      assign tag_fill = atag_q;
      assign dat_fill = mem_data;
      assign tag_bad  = 1'b0;
      assign dat_bad  = 1'b0;
    end
  endgenerate

  wire [TAG_W-1:0]  tmask = TAG_W'(1) << inj_bit_q;
  wire [DATA_W-1:0] dmask = DATA_W'(1) << inj_bit_q;
  assign tag_wd = inj_we ? (tag_q ^ TW'(tmask)) : tag_fill;
  assign dat_wd = inj_we ? (dat_q ^ DW'(dmask)) : dat_fill;

  always_ff @(posedge clk) begin
    if (fill_we || (inj_we && !inj_sel_q)) tag_ram[wr_idx] <= tag_wd;
    if (fill_we || (inj_we &&  inj_sel_q)) dat_ram[wr_idx] <= dat_wd;
    tag_q <= tag_ram[rd_idx];
    dat_q <= dat_ram[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vld       <= '0;
      addr_q    <= '0;
      inj_sel_q <= 1'b0;
      inj_idx_q <= '0;
      inj_bit_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take_inj) begin
            state     <= S_INJ;
            inj_sel_q <= inj_sel;
            inj_idx_q <= inj_idx;
            inj_bit_q <= inj_bit;
          end else if (take_req) begin
            state  <= S_LOOK;
            addr_q <= req_addr;
          end
        end
        S_LOOK: state <= hit_c ? S_IDLE : S_FILL;
        S_FILL: if (mem_ack) begin
          state       <= S_IDLE;
          vld[idx_q]  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign look_vld  = (state == S_LOOK) && vld[idx_q];
  assign hit_c     = look_vld && (tag_q[TAG_W-1:0] == atag_q) && !tag_bad && !dat_bad;
  assign par_err   = {look_vld && dat_bad, look_vld && tag_bad};
  assign req_ready = (state == S_IDLE) && !inj_en;
  assign rsp_valid = hit_c || fill_we;
  assign rsp_hit   = hit_c;
  assign rsp_data  = (state == S_FILL) ? mem_data : dat_q[DATA_W-1:0];
  assign mem_req   = (state == S_FILL);
  assign mem_addr  = addr_q;
endmodule

// File: rtl/parity_dm_cache_chk.sv
module parity_dm_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [1:0]        par_err,
  input logic              inj_en
);
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_hit_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (par_err == 2'b00));

  p_err_refill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err != 2'b00) |=> mem_req);

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err != 2'b00) |=> (par_err == 2'b00));

  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !req_ready);

  p_inj_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> !req_ready);
endmodule

bind parity_dm_cache parity_dm_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .par_err(par_err), .inj_en(inj_en)
);

// File: tb/test_parity_dm_cache.sv
module test_parity_dm_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [11:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        mem_req, mem_ack = 1'b0;
  logic [11:0] mem_addr;
  logic [31:0] mem_data = '0;
  logic [1:0]  par_err;
  logic        inj_en = 1'b0, inj_sel = 1'b0;
  logic [3:0]  inj_idx = '0;
  logic [4:0]  inj_bit = '0;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  parity_dm_cache i_parity_dm_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .par_err(par_err), .inj_en(inj_en), .inj_sel(inj_sel), .inj_idx(inj_idx),
    .inj_bit(inj_bit));

  typedef struct packed {
    logic [1:0]  op;   // 0 lookup, 1 corrupt data, 2 corrupt tag
    logic [11:0] a;    // address, or index for a corruption
    logic [4:0]  b;    // bit to flip
    logic        h;    // expected hit
    logic [1:0]  e;    // expected par_err
  } vec_t;

  localparam vec_t VEC [19] = '{
    '{2'd0, 12'h013, 5'd0,  1'b0, 2'b00},  // R1 R2 cold miss
    '{2'd0, 12'h013, 5'd0,  1'b1, 2'b00},  // R3 R6
    '{2'd0, 12'h024, 5'd0,  1'b0, 2'b00},
    '{2'd0, 12'h113, 5'd0,  1'b0, 2'b00},  // R4 tag mismatch
    '{2'd0, 12'h013, 5'd0,  1'b0, 2'b00},  // R4 evicted
    '{2'd0, 12'h013, 5'd0,  1'b1, 2'b00},
    '{2'd1, 12'h003, 5'd5,  1'b0, 2'b00},
    '{2'd0, 12'h013, 5'd0,  1'b0, 2'b10},  // R7
    '{2'd0, 12'h013, 5'd0,  1'b1, 2'b00},  // R9
    '{2'd2, 12'h004, 5'd0,  1'b0, 2'b00},
    '{2'd0, 12'h024, 5'd0,  1'b0, 2'b01},  // R8
    '{2'd0, 12'h024, 5'd0,  1'b1, 2'b00},  // R9
    '{2'd1, 12'h007, 5'd31, 1'b0, 2'b00},
    '{2'd0, 12'h037, 5'd0,  1'b0, 2'b00},  // R11 invalid entry silent
    '{2'd0, 12'h037, 5'd0,  1'b1, 2'b00},
    '{2'd2, 12'h003, 5'd7,  1'b0, 2'b00},
    '{2'd0, 12'h813, 5'd0,  1'b0, 2'b01},  // R8 bits match, parity bad
    '{2'd0, 12'h813, 5'd0,  1'b1, 2'b00},
    '{2'd0, 12'h013, 5'd0,  1'b0, 2'b00}
  };

  function automatic logic [31:0] mdat(input logic [11:0] a);
    return {a, ~a, 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic inject(input logic sel, input logic [3:0] idx, input logic [4:0] b, input bit with_req);
    @(negedge clk);
    inj_en = 1'b1; inj_sel = sel; inj_idx = idx; inj_bit = b;
    if (with_req) begin req_valid = 1'b1; req_addr = 12'h013; end
    #1 chk(req_ready == 1'b0, "R10 ready low during inject", 32'(req_ready), 32'd0);
    @(negedge clk);
    inj_en = 1'b0; req_valid = 1'b0;
    chk(req_ready == 1'b0 && mem_req == 1'b0 && rsp_valid == 1'b0, "R10 inject busy",
        {29'd0, req_ready, mem_req, rsp_valid}, 32'd0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle after inject", 32'(req_ready), 32'd1);
  endtask

  task automatic lookup(input logic [11:0] a, input bit h, input logic [1:0] e, input int lat);
    @(negedge clk);
    chk(req_ready == 1'b1, "R5 ready in idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(par_err == e, (e[1] ? "R7 data error" : (e[0] ? "R8 tag error" : "R11 R6 no error")),
        32'(par_err), 32'(e));
    chk(rsp_valid == h && rsp_hit == h, "R3 hit decision", {30'd0, rsp_valid, rsp_hit}, {30'd0, h, h});
    chk(req_ready == 1'b0, "R5 ready low while busy", 32'(req_ready), 32'd0);
    if (h) begin
      chk(rsp_data == mdat(a), "R3 hit data", rsp_data, mdat(a));
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_req == 1'b0, "R5 R3 idle after hit",
          {30'd0, req_ready, mem_req}, 32'd2);
    end else begin
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(mem_req == 1'b1 && mem_addr == a && rsp_valid == 1'b0, "R2 request held",
            {19'd0, mem_req, mem_addr}, {19'd0, 1'b1, a});
      end
      @(negedge clk);
      chk(mem_req == 1'b1 && mem_addr == a, "R2 refill request", {19'd0, mem_req, mem_addr}, {19'd0, 1'b1, a});
      mem_ack = 1'b1; mem_data = mdat(a);
      #1;
      chk(rsp_valid == 1'b1 && rsp_hit == 1'b0, "R2 refill response",
          {30'd0, rsp_valid, rsp_hit}, 32'd2);
      chk(rsp_data == mdat(a), "R2 refill data", rsp_data, mdat(a));
      @(negedge clk);
      mem_ack = 1'b0; mem_data = '0;
      chk(req_ready == 1'b1 && mem_req == 1'b0, "R5 idle after refill",
          {30'd0, req_ready, mem_req}, 32'd2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0 && par_err == 2'b00,
        "R1 reset outputs", {28'd0, req_ready, mem_req, rsp_valid, |par_err}, 32'h8);

    for (int i = 0; i < 19; i++) begin
      if (VEC[i].op == 2'd0) lookup(VEC[i].a, VEC[i].h, VEC[i].e, i % 3);
      else inject(VEC[i].op == 2'd1, VEC[i].a[3:0], VEC[i].b, 1'b0);
    end

    // R10: injection wins over a simultaneous request; the request is not taken
    inject(1'b1, 4'd3, 5'd0, 1'b1);
    lookup(12'h013, 1'b0, 2'b10, 1);
    lookup(12'h013, 1'b1, 2'b00, 0);

    // R10: a flip on a tag bit also at the matching index of another entry
    lookup(12'h0A5, 1'b0, 2'b00, 2);
    inject(1'b0, 4'd5, 5'd2, 1'b0);
    lookup(12'h0A5, 1'b0, 2'b01, 0);
    lookup(12'h0A5, 1'b1, 2'b00, 0);

    // R1: reset mid-life invalidates everything, even corrupted entries stay silent
    inject(1'b1, 4'd5, 5'd9, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0, "R1 reset again", {30'd0, req_ready, mem_req}, 32'd2);
    lookup(12'h0A5, 1'b0, 2'b00, 0);
    lookup(12'h013, 1'b0, 2'b00, 1);
    lookup(12'h0A5, 1'b1, 2'b00, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule